// File: doc/BRIEF.md
# Single-Word Peripheral-to-Memory DMA Engine

This block copies one data word from a peripheral's register to a memory location over a shared system bus. It does this without the processor running any service code. The processor first loads a source address and a destination address through a small configuration port.

After that, a request from the peripheral starts a fixed handshake. The engine asks the processor for the bus and waits for the grant. While it holds the grant, it acknowledges the peripheral, reads the word from the source address and writes it to the destination address. It then withdraws both its bus request and its acknowledge.

The engine returns to idle only when the processor has taken the bus back and the peripheral has dropped its request. Each copy is therefore bracketed by a fully closed four-phase exchange. While the engine does not own the bus, its bus outputs are held at zero, so a plain OR-style bus merge works.

Top module: `pmdma_ctrl`

## Requirements
- R1: After reset, the source address is 0x8000 and the destination address is 0x0001. Bus request, acknowledge, read strobe, write strobe, bus address and write data are all 0.
- R2: When the engine is idle and periph_req is sampled high at a clock edge, bus_req is high after that edge. Acknowledge and both strobes stay low for as long as bus_grant stays low.
- R3: When the engine is waiting and bus_grant is sampled high at a clock edge, the next cycle carries periph_ack=1, bus_rd=1 and bus_addr equal to the source address.
- R4: The cycle after the read carries bus_wr=1 and bus_addr equal to the destination address. bus_wdata in that cycle is the bus_rdata value present during the read cycle. Exactly one write occurs per transfer.
- R5: The cycle after the write, bus_req and periph_ack are both 0.
- R6: bus_rd, bus_wr, bus_addr and bus_wdata are 0 in every cycle in which bus_grant is low or no read or write is in progress.
- R7: After a transfer, the engine raises bus_req again only once it has sampled bus_grant low and periph_req low. A request held high from the finished transfer, or a grant still held high, starts nothing.
- R8: A configuration write uses cfg_sel=0 for the source address and cfg_sel=1 for the destination address. It takes effect only when the engine is idle; a write at any other time is ignored.
- R9: bus_rd and bus_wr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 source, 1 destination |
| cfg_wdata | input | ADDR_W | Configuration write value |
| periph_req | input | 1 | Peripheral service request |
| periph_ack | output | 1 | Acknowledge to the peripheral |
| bus_req | output | 1 | Bus request to the processor |
| bus_grant | input | 1 | Bus grant from the processor |
| bus_addr | output | ADDR_W | System bus address, 0 when not owned |
| bus_rd | output | 1 | Single-word read strobe |
| bus_wr | output | 1 | Single-word write strobe |
| bus_wdata | output | DATA_W | Write data, 0 outside the write cycle |
| bus_rdata | input | DATA_W | Read data, valid in the read cycle |

## Verification
Every output is a decode of a registered state, so each result is due exactly one clock edge after the input that causes it:
- bus_req follows the sampled request.
- The read follows the sampled grant.
- The write follows the read.
- The release follows the write.

The bench drives inputs and samples outputs on the falling edge. Each check therefore lands in the first cycle the result may appear. The checks also confirm the result is absent in the cycles before it, including a swept number of cycles in which the grant is withheld. The closing order of the handshake is probed by holding one of grant or request high for several cycles and checking that no new bus request appears.

// File: rtl/pmdma_pkg.sv
package pmdma_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WAIT  = 3'd1,
      ST_READ  = 3'd2,
      ST_WRITE = 3'd3,
      ST_CLOSE = 3'd4
   } pmdma_state_e;

   localparam int unsigned CFG_NREG = 2;
   localparam int unsigned CFG_SRC  = 0;
   localparam int unsigned CFG_DST  = 1;
endpackage

// File: rtl/pmdma_addr_regs.sv
module pmdma_addr_regs
   import pmdma_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter logic [ADDR_W-1:0] SRC_RST = 16'h8000,
   parameter logic [ADDR_W-1:0] DST_RST = 16'h0001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   output logic [ADDR_W-1:0] src_addr,
   output logic [ADDR_W-1:0] dst_addr
);
   logic [ADDR_W-1:0] regs_q [CFG_NREG];

   for (genvar g = 0; g < CFG_NREG; g++) begin : g_reg
      localparam logic [ADDR_W-1:0] RST_V = (g == CFG_SRC) ? SRC_RST : DST_RST;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs_q[g] <= RST_V;
         else if (wr_en && (int'(wr_sel) == g))
            regs_q[g] <= wr_data;
      end
   end

   assign src_addr = regs_q[CFG_SRC];
   assign dst_addr = regs_q[CFG_DST];
endmodule

// File: rtl/pmdma_seq.sv
module pmdma_seq
   import pmdma_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         periph_req,
   input  logic         bus_grant,
   output pmdma_state_e state,
   output logic         idle,
   output logic         periph_ack,
   output logic         bus_req
);
   pmdma_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (periph_req) state_d = ST_WAIT;
         ST_WAIT:  if (bus_grant)  state_d = ST_READ;
         ST_READ:  state_d = ST_WRITE;
         ST_WRITE: state_d = ST_CLOSE;
         ST_CLOSE: if (!bus_grant && !periph_req) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign state      = state_q;
   assign idle       = (state_q == ST_IDLE);
   assign periph_ack = (state_q == ST_READ) || (state_q == ST_WRITE);
   assign bus_req    = (state_q == ST_WAIT) || periph_ack;
endmodule

// File: rtl/pmdma_bus_drv.sv
module pmdma_bus_drv
   import pmdma_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  pmdma_state_e      state,
   input  logic              bus_grant,
   input  logic [ADDR_W-1:0] src_addr,
   input  logic [ADDR_W-1:0] dst_addr,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic [DATA_W-1:0] bus_wdata
);
   logic [DATA_W-1:0] hold_q;
   logic              own, in_rd, in_wr;

   assign own   = bus_grant;
   assign in_rd = own && (state == ST_READ);
   assign in_wr = own && (state == ST_WRITE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hold_q <= '0;
      else if (in_rd) hold_q <= bus_rdata;
   end

   assign bus_rd    = in_rd;
   assign bus_wr    = in_wr;
   assign bus_addr  = in_rd ? src_addr : (in_wr ? dst_addr : '0);
   assign bus_wdata = in_wr ? hold_q : '0;
endmodule

// File: rtl/pmdma_ctrl.sv
module pmdma_ctrl
   import pmdma_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8,
   parameter logic [ADDR_W-1:0] SRC_RST = 16'h8000,
   parameter logic [ADDR_W-1:0] DST_RST = 16'h0001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              periph_req,
   output logic              periph_ack,
   output logic              bus_req,
   input  logic              bus_grant,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata
);
   if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_aw
      $fatal(1, "pmdma_ctrl: ADDR_W out of range");
   end
   if (DATA_W < 1 || DATA_W > 128) begin : g_bad_dw
      $fatal(1, "pmdma_ctrl: DATA_W out of range");
   end

   pmdma_state_e      state;
   logic              idle;
   logic [ADDR_W-1:0] src_addr, dst_addr;

   pmdma_seq u_seq (
      .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .bus_grant(bus_grant),
      .state(state), .idle(idle), .periph_ack(periph_ack), .bus_req(bus_req)
   );

   pmdma_addr_regs #(.ADDR_W(ADDR_W), .SRC_RST(SRC_RST), .DST_RST(DST_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we && idle), .wr_sel(cfg_sel),
      .wr_data(cfg_wdata), .src_addr(src_addr), .dst_addr(dst_addr)
   );

   pmdma_bus_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
      .clk(clk), .rst_n(rst_n), .state(state), .bus_grant(bus_grant),
      .src_addr(src_addr), .dst_addr(dst_addr), .bus_rdata(bus_rdata),
      .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata)
   );
endmodule

// File: rtl/pmdma_ctrl_chk.sv
module pmdma_ctrl_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              periph_req,
   input logic              periph_ack,
   input logic              bus_req,
   input logic              bus_grant,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata
);
   a_r6_gated_when_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_grant |-> (!bus_rd && !bus_wr && bus_addr == '0 && bus_wdata == '0));

   a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));

   a_r3_ack_implies_request: assert property (@(posedge clk) disable iff (!rst_n)
      periph_ack |-> bus_req);

   a_r4_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_grant) |=> (bus_wr || !bus_grant));

   a_r5_release_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |=> (!bus_req && !periph_ack));

   a_r2_request_needs_periph: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req) |-> $past(periph_req));
endmodule

bind pmdma_ctrl pmdma_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .periph_ack(periph_ack),
   .bus_req(bus_req), .bus_grant(bus_grant), .bus_addr(bus_addr),
   .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata)
);

// File: tb/pmdma_ctrl_tb.sv
module pmdma_ctrl_tb;
   localparam int AW = 16;
   localparam int DW = 8;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          cfg_we = 0, cfg_sel = 0;
   logic [AW-1:0] cfg_wdata = '0;
   logic          periph_req = 0, bus_grant = 0;
   logic          periph_ack, bus_req, bus_rd, bus_wr;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata, bus_rdata;
   int            n_run = 0, n_fail = 0;
   bit            done = 0;

   always #10 clk = ~clk;

   function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hA5;
   endfunction

   assign bus_rdata = bus_rd ? mem_word(bus_addr) : 8'h00;

   pmdma_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .periph_req(periph_req), .periph_ack(periph_ack), .bus_req(bus_req),
      .bus_grant(bus_grant), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic quiet_bus(input string req);
      chk(req, {bus_rd, bus_wr, bus_addr, bus_wdata}, 32'h0);
   endtask

   task automatic cfg_write(input logic sel, input logic [AW-1:0] v);
      @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = v;
      @(negedge clk); cfg_we = 0;
   endtask

   // one transfer; gdly cycles of withheld grant; order 0 drops grant first
   task automatic xfer(input logic [AW-1:0] src, input logic [AW-1:0] dst,
                       input int gdly, input int order, input bit poke_cfg);
      @(negedge clk); periph_req = 1;
      @(negedge clk);
      chk("R2 bus_req", bus_req, 1);
      chk("R2 ack low", periph_ack, 0);
      quiet_bus("R2 bus quiet");
      for (int i = 0; i < gdly; i++) begin
         if (poke_cfg && i == 0) begin cfg_we = 1; cfg_sel = 0; cfg_wdata = 16'hDEAD; end
         @(negedge clk); cfg_we = 0;
         chk("R2 still waiting", {bus_req, periph_ack}, 2'b10);
         quiet_bus("R6 no grant quiet");
      end
      bus_grant = 1;
      @(negedge clk);
      chk("R3 ack", periph_ack, 1);
      chk("R3 read", {bus_rd, bus_wr}, 2'b10);
      chk("R3 src addr", bus_addr, src);
      @(negedge clk);
      chk("R4 write", {bus_rd, bus_wr}, 2'b01);
      chk("R4 dst addr", bus_addr, dst);
      chk("R4 data", bus_wdata, mem_word(src));
      @(negedge clk);
      chk("R5 release", {bus_req, periph_ack}, 2'b00);
      quiet_bus("R6 granted but idle bus");
      if (order == 0) bus_grant = 0; else periph_req = 0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R7 no restart", {bus_req, bus_wr, bus_rd}, 3'b000);
      end
      if (order == 0) periph_req = 0; else bus_grant = 0;
      @(negedge clk);
      chk("R7 closed", bus_req, 0);
   endtask

   initial begin
      repeat (2000) @(negedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      chk("R1 outputs", {bus_req, periph_ack}, 2'b00);
      quiet_bus("R1 bus");
      rst_n = 1;
      // R1 defaults observed through the first transfer
      xfer(16'h8000, 16'h0001, 0, 0, 0);
      // R8 write during wait ignored, source stays
      xfer(16'h8000, 16'h0001, 2, 1, 1);
      // R8 sweep of addresses, grant delays and close orders
      for (int k = 0; k < 6; k++) begin
         logic [AW-1:0] s, d;
         s = 16'h1234 + 16'(k * 16'h0F31);
         d = 16'h4000 ^ 16'(k * 16'h0107);
         cfg_write(0, s);
         cfg_write(1, d);
         xfer(s, d, k % 4, k % 2, 0);
      end
      // R7: request issued right after close starts at once
      @(negedge clk); periph_req = 1;
      @(negedge clk);
      chk("R7 new request accepted", bus_req, 1);
      bus_grant = 1;
      @(negedge clk);
      chk("R9 read only", {bus_rd, bus_wr}, 2'b10);
      @(negedge clk);
      chk("R9 write only", {bus_rd, bus_wr}, 2'b01);
      bus_grant = 0; periph_req = 0;
      repeat (2) @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule